// File: doc/BRIEF.md
# Multicycle Control Sequencer

This block is the control unit of a register machine whose datapath elements share a single data bus. It holds no stored microprogram. A free-running step counter moves through six states. Each state is decoded into a pulse that is high for one clock period. Every datapath strobe is either such a pulse on its own, or a pulse ANDed with a class bit or a register-select bit taken from the instruction register contents.

The first three steps of every instruction fetch it. The program counter goes to the address register and to the ALU. The incremented value returns to the program counter while memory is read. The returned byte is then placed in the instruction register. The last three steps depend on the opcode:

- **Register add:** two operands are fed to the ALU and the sum is written back.
- **Memory load:** a register supplies the address and the returned data is stored in a register.
- **Jump:** a sum is routed into the program counter.
- **Conditional jump:** as a jump, but the final program-counter load happens only when the ALU flags report a negative or zero result.

The surrounding datapath owns the instruction register. It presents that register's contents on `instr` and updates them on the clock edge that ends a cycle in which `ir_load` is high.

Top module: `mc_sequencer`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), every output strobe is 0. The first cycle with `rst_n` high is fetch step 1, and this also holds when reset arrives in the middle of an instruction.
- R2: The step counter advances once per clock through steps 1 to 6 and then returns to step 1. Each step pulse lasts one clock, so the fetch pattern repeats every six cycles.
- R3: Fetch step 1 asserts exactly `pc_drive`, `mar_load` and `alu_load`.
- R4: Fetch step 2 asserts exactly `alu_inc_drive`, `pc_load` and `mem_read`.
- R5: Fetch step 3 asserts exactly `mdr_drive` and `ir_load`.
- R6: The instruction byte is decoded as follows. Bits [7:6] are the opcode: 00 add, 01 load, 10 jump, 11 conditional jump. Bits [5:3] are field A and bits [2:0] are field B. Register index i from 0 to 6 maps to bit i of `gpr_load`/`gpr_drive`, and index 7 maps to the program counter strobes `pc_load`/`pc_drive`.
- R7: Add runs three steps. Step 4 drives register A together with `alu_load`. Step 5 drives register B together with `alu_load`. Step 6 asserts `alu_add_drive` and loads register A.
- R8: Load runs three steps. Step 4 drives register A together with `mar_load`. Step 5 asserts only `mem_read`. Step 6 asserts `mdr_drive` and loads register B.
- R9: Jump uses the add pattern in steps 4 and 5. Step 6 asserts `alu_add_drive` and `pc_load`, and loads no general register.
- R10: Conditional jump matches jump, except that `pc_load` in step 6 is asserted only if `alu_neg` or `alu_zero` is high in that cycle. `alu_add_drive` fires in step 6 in every case.
- R11: In any cycle, at most one of `pc_drive`, `alu_inc_drive`, `alu_add_drive`, `mdr_drive` and the `gpr_drive` bits is high.
- R12: A register field holding index 7 selects the program counter. An add with A = 7 loads the program counter in step 6 and so acts as a jump. A load with A = 7 drives the program counter in step 4, and a load with B = 7 loads it in step 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr | input | 8 | Current instruction register contents |
| alu_neg | input | 1 | ALU reports a negative last result |
| alu_zero | input | 1 | ALU reports a zero last result |
| pc_load | output | 1 | Program counter loads from the bus |
| pc_drive | output | 1 | Program counter drives the bus |
| mar_load | output | 1 | Memory address register loads from the bus |
| alu_load | output | 1 | ALU operand register loads from the bus |
| alu_inc_drive | output | 1 | ALU increment result drives the bus |
| alu_add_drive | output | 1 | ALU sum drives the bus |
| mem_read | output | 1 | Memory read request |
| mdr_drive | output | 1 | Memory data register drives the bus |
| ir_load | output | 1 | Instruction register loads from the bus |
| gpr_load | output | 7 | Load enable of general registers 0 to 6 |
| gpr_drive | output | 7 | Bus drive enable of general registers 0 to 6 |

## Verification
The assertions assume that `instr` changes only on the edge that closes an `ir_load` cycle, so it stays steady through steps 4 to 6. They also assume the flags are valid whenever they are consulted. The stimulus follows this rule: the bench changes its instruction-register model only at the start of step 4 and holds both flags steady for a whole instruction. The bench covers every opcode. It also covers both register fields at index 7, all four flag combinations for the conditional jump, and a reset that cuts an instruction short after step 4.

// File: rtl/mcs_pkg.sv
`timescale 1ns/1ps
// Package: shared opcode encoding for the multicycle control sequencer.
// Assumes the opcode occupies the top OPC_W bits of the instruction byte.
package mcs_pkg;

    localparam int OPC_W = 2;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD   = 2'b00,
        OP_LOAD  = 2'b01,
        OP_JUMP  = 2'b10,
        OP_CJUMP = 2'b11
    } mcs_op_e;

endpackage

// File: rtl/mcs_step_counter.sv
`timescale 1ns/1ps
// Module: mcs_step_counter
// A binary counter that advances every clock and wraps after the last step.
// Each count is decoded into a pulse that is high for one clock period.
// Assumes: rst_n is synchronous and active low, and all pulses stay low
// while it is asserted.
module mcs_step_counter #(
    parameter int NUM_STEPS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [NUM_STEPS-1:0] step_pulse
);

    localparam int             CNT_W = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_STEPS - 1);

    logic [CNT_W-1:0] cnt;

    // Advance the step count, wrapping from the last step back to the first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Decode each count value into its own one-cycle pulse.
    for (genvar g = 0; g < NUM_STEPS; g++) begin : g_pulse
        assign step_pulse[g] = rst_n && (cnt == CNT_W'(g));
    end

    // R2
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LAST) |=> (cnt == '0));

    // R2
    step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(step_pulse));

endmodule

// File: rtl/mcs_instr_decode.sv
`timescale 1ns/1ps
// Module: mcs_instr_decode
// Splits the instruction byte into four opcode class bits and two one-hot
// register selects, field A and field B.
// Assumes: the opcode is in the top bits, followed by field A and then
// field B.
module mcs_instr_decode
    import mcs_pkg::*;
#(
    parameter  int IDX_W   = 3,
    localparam int NUM_IDX = 1 << IDX_W,
    localparam int INSTR_W = OPC_W + 2 * IDX_W
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               is_add,
    output logic               is_load,
    output logic               is_jump,
    output logic               is_cjump,
    output logic [NUM_IDX-1:0] sel_a,
    output logic [NUM_IDX-1:0] sel_b
);

    mcs_op_e          op;
    logic [IDX_W-1:0] field_a;
    logic [IDX_W-1:0] field_b;

    assign op      = mcs_op_e'(instr[INSTR_W-1 -: OPC_W]);
    assign field_a = instr[2*IDX_W-1 -: IDX_W];
    assign field_b = instr[IDX_W-1:0];

    // Turn the opcode into mutually exclusive class bits.
    always_comb begin
        is_add   = 1'b0;
        is_load  = 1'b0;
        is_jump  = 1'b0;
        is_cjump = 1'b0;
        unique case (op)
            OP_ADD:   is_add   = 1'b1;
            OP_LOAD:  is_load  = 1'b1;
            OP_JUMP:  is_jump  = 1'b1;
            OP_CJUMP: is_cjump = 1'b1;
            default:  ;
        endcase
    end

    // Expand both register fields into one-hot selects.
    for (genvar g = 0; g < NUM_IDX; g++) begin : g_sel
        assign sel_a[g] = (field_a == IDX_W'(g));
        assign sel_b[g] = (field_b == IDX_W'(g));
    end

endmodule

// File: rtl/mcs_strobe_gen.sv
`timescale 1ns/1ps
// Module: mcs_strobe_gen
// Forms every datapath strobe by ANDing the step pulses with the opcode
// class bits and the register selects. The top register index stands for
// the program counter, and the condition flags gate the conditional jump.
// Assumes: class bits and selects stay steady from step 4 to step 6.
module mcs_strobe_gen #(
    parameter  int IDX_W     = 3,
    parameter  int NUM_STEPS = 6,
    localparam int NUM_IDX   = 1 << IDX_W,
    localparam int NUM_GPR   = NUM_IDX - 1,
    localparam int PC_IDX    = NUM_IDX - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_STEPS-1:0] step_pulse,
    input  logic                 is_add,
    input  logic                 is_load,
    input  logic                 is_jump,
    input  logic                 is_cjump,
    input  logic [NUM_IDX-1:0]   sel_a,
    input  logic [NUM_IDX-1:0]   sel_b,
    input  logic                 alu_neg,
    input  logic                 alu_zero,
    output logic                 pc_load,
    output logic                 pc_drive,
    output logic                 mar_load,
    output logic                 alu_load,
    output logic                 alu_inc_drive,
    output logic                 alu_add_drive,
    output logic                 mem_read,
    output logic                 mdr_drive,
    output logic                 ir_load,
    output logic [NUM_GPR-1:0]   gpr_load,
    output logic [NUM_GPR-1:0]   gpr_drive
);

    localparam int ST_F1 = 0;
    localparam int ST_F2 = 1;
    localparam int ST_F3 = 2;
    localparam int ST_X1 = 3;
    localparam int ST_X2 = 4;
    localparam int ST_X3 = 5;

    logic               alu_op;
    logic               cond_ok;
    logic [NUM_IDX-1:0] load_sel;
    logic [NUM_IDX-1:0] drive_sel;

    assign alu_op  = is_add | is_jump | is_cjump;
    assign cond_ok = alu_neg | alu_zero;

    // Per-index register strobes: drive A in step 4, drive B in step 5 for
    // ALU classes, then load A (add) or B (load) in step 6.
    for (genvar g = 0; g < NUM_IDX; g++) begin : g_reg
        assign drive_sel[g] = (step_pulse[ST_X1] & sel_a[g])
                            | (step_pulse[ST_X2] & alu_op & sel_b[g]);
        assign load_sel[g]  = (step_pulse[ST_X3] & is_add  & sel_a[g])
                            | (step_pulse[ST_X3] & is_load & sel_b[g]);
    end

    assign gpr_load  = load_sel[NUM_GPR-1:0];
    assign gpr_drive = drive_sel[NUM_GPR-1:0];

    // Fixed fetch strobes merged with the strobes of each instruction class.
    always_comb begin
        pc_drive      = step_pulse[ST_F1] | drive_sel[PC_IDX];
        mar_load      = step_pulse[ST_F1] | (step_pulse[ST_X1] & is_load);
        alu_load      = step_pulse[ST_F1]
                      | ((step_pulse[ST_X1] | step_pulse[ST_X2]) & alu_op);
        alu_inc_drive = step_pulse[ST_F2];
        mem_read      = step_pulse[ST_F2] | (step_pulse[ST_X2] & is_load);
        mdr_drive     = step_pulse[ST_F3] | (step_pulse[ST_X3] & is_load);
        ir_load       = step_pulse[ST_F3];
        alu_add_drive = step_pulse[ST_X3] & alu_op;
        pc_load       = step_pulse[ST_F2]
                      | load_sel[PC_IDX]
                      | (step_pulse[ST_X3] & is_jump)
                      | (step_pulse[ST_X3] & is_cjump & cond_ok);
    end

    // R11
    one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_drive, alu_inc_drive, alu_add_drive, mdr_drive, gpr_drive}));

    // R5
    ir_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |-> $past(mem_read));

    // R8
    addr_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mar_load |=> mem_read);

    // R10
    cjump_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cjump && alu_add_drive && !alu_neg && !alu_zero) |-> !pc_load);

endmodule

// File: rtl/mc_sequencer.sv
`timescale 1ns/1ps
// Module: mc_sequencer (top)
// A counter-driven control unit for a single-bus register machine. It runs
// a three-step fetch and then three instruction-specific steps for add,
// load, jump and conditional jump.
// Assumes: the datapath updates instr on the edge that closes an ir_load
// cycle.
module mc_sequencer #(
    parameter  int IDX_W     = 3,
    parameter  int NUM_STEPS = 6,
    localparam int INSTR_W   = mcs_pkg::OPC_W + 2 * IDX_W,
    localparam int NUM_GPR   = (1 << IDX_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic               alu_neg,
    input  logic               alu_zero,
    output logic               pc_load,
    output logic               pc_drive,
    output logic               mar_load,
    output logic               alu_load,
    output logic               alu_inc_drive,
    output logic               alu_add_drive,
    output logic               mem_read,
    output logic               mdr_drive,
    output logic               ir_load,
    output logic [NUM_GPR-1:0] gpr_load,
    output logic [NUM_GPR-1:0] gpr_drive
);

    localparam int NUM_IDX = 1 << IDX_W;

    logic [NUM_STEPS-1:0] step_pulse;
    logic                 is_add;
    logic                 is_load;
    logic                 is_jump;
    logic                 is_cjump;
    logic [NUM_IDX-1:0]   sel_a;
    logic [NUM_IDX-1:0]   sel_b;

    mcs_step_counter #(.NUM_STEPS(NUM_STEPS)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_pulse (step_pulse)
    );

    mcs_instr_decode #(.IDX_W(IDX_W)) u_decode (
        .instr    (instr),
        .is_add   (is_add),
        .is_load  (is_load),
        .is_jump  (is_jump),
        .is_cjump (is_cjump),
        .sel_a    (sel_a),
        .sel_b    (sel_b)
    );

    mcs_strobe_gen #(.IDX_W(IDX_W), .NUM_STEPS(NUM_STEPS)) u_strobe (
        .clk           (clk),
        .rst_n         (rst_n),
        .step_pulse    (step_pulse),
        .is_add        (is_add),
        .is_load       (is_load),
        .is_jump       (is_jump),
        .is_cjump      (is_cjump),
        .sel_a         (sel_a),
        .sel_b         (sel_b),
        .alu_neg       (alu_neg),
        .alu_zero      (alu_zero),
        .pc_load       (pc_load),
        .pc_drive      (pc_drive),
        .mar_load      (mar_load),
        .alu_load      (alu_load),
        .alu_inc_drive (alu_inc_drive),
        .alu_add_drive (alu_add_drive),
        .mem_read      (mem_read),
        .mdr_drive     (mdr_drive),
        .ir_load       (ir_load),
        .gpr_load      (gpr_load),
        .gpr_drive     (gpr_drive)
    );

endmodule

// File: tb/mc_sequencer_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: run_steps pushes the expected strobe vector of each step
// into a queue, and a negedge monitor pops it and compares it with the outputs.
module mc_sequencer_bench;

    localparam int NUM_GPR = 7;
    localparam int VEC_W   = 9 + 2 * NUM_GPR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] cur_ir = 8'h00;
    logic nf = 1'b0;
    logic zf = 1'b0;

    logic pc_load, pc_drive, mar_load, alu_load, alu_inc_drive, alu_add_drive;
    logic mem_read, mdr_drive, ir_load;
    logic [NUM_GPR-1:0] gpr_load, gpr_drive;

    always #2 clk = ~clk;

    mc_sequencer u_mc_sequencer (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr         (cur_ir),
        .alu_neg       (nf),
        .alu_zero      (zf),
        .pc_load       (pc_load),
        .pc_drive      (pc_drive),
        .mar_load      (mar_load),
        .alu_load      (alu_load),
        .alu_inc_drive (alu_inc_drive),
        .alu_add_drive (alu_add_drive),
        .mem_read      (mem_read),
        .mdr_drive     (mdr_drive),
        .ir_load       (ir_load),
        .gpr_load      (gpr_load),
        .gpr_drive     (gpr_drive)
    );

    logic [VEC_W-1:0] act;
    assign act = {pc_load, pc_drive, mar_load, alu_load, alu_inc_drive,
                  alu_add_drive, mem_read, mdr_drive, ir_load, gpr_load, gpr_drive};

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    logic [VEC_W-1:0] exp_q[$];
    string            tag_q[$];
    logic [VEC_W-1:0] m_exp;
    string            m_tag;

    // Expected strobes of one step, built from the requirements.
    function automatic logic [VEC_W-1:0] model(int s, logic [7:0] ins, logic n, logic z);
        logic pl = 0, pd = 0, ml = 0, al = 0, ai = 0, aa = 0, mr = 0, md = 0, il = 0;
        logic [NUM_GPR-1:0] gl = '0;
        logic [NUM_GPR-1:0] gd = '0;
        int a = int'(ins[5:3]);
        int b = int'(ins[2:0]);
        logic [1:0] op = ins[7:6];
        case (s)
            1: begin pd = 1; ml = 1; al = 1; end
            2: begin ai = 1; pl = 1; mr = 1; end
            3: begin md = 1; il = 1; end
            4: begin
                if (op == 2'b01) ml = 1; else al = 1;
                if (a == 7) pd = 1; else gd[a] = 1;
            end
            5: begin
                if (op == 2'b01) mr = 1;
                else begin
                    al = 1;
                    if (b == 7) pd = 1; else gd[b] = 1;
                end
            end
            default: begin
                case (op)
                    2'b00: begin aa = 1; if (a == 7) pl = 1; else gl[a] = 1; end
                    2'b01: begin md = 1; if (b == 7) pl = 1; else gl[b] = 1; end
                    2'b10: begin aa = 1; pl = 1; end
                    default: begin aa = 1; if (n || z) pl = 1; end
                endcase
            end
        endcase
        return {pl, pd, ml, al, ai, aa, mr, md, il, gl, gd};
    endfunction

    function automatic string tagfor(int s, logic [7:0] ins, string extra);
        string t;
        case (s)
            1: t = "R2/R3";
            2: t = "R2/R4";
            3: t = "R2/R5";
            default: begin
                case (ins[7:6])
                    2'b00: t = "R6/R7";
                    2'b01: t = "R6/R8";
                    2'b10: t = "R9";
                    default: t = "R10";
                endcase
                if (ins[5:3] == 3'd7 || ins[2:0] == 3'd7) t = {t, "/R12"};
            end
        endcase
        if (s == 1 && extra != "") t = {extra, "/", t};
        return t;
    endfunction

    // Driver: push the expectation for each step, then let the step run.
    task automatic run_steps(logic [7:0] ins, logic n, logic z, int nsteps, string extra);
        for (int s = 1; s <= nsteps; s++) begin
            if (s == 4) cur_ir = ins;
            nf = n;
            zf = z;
            exp_q.push_back(model(s, cur_ir, n, z));
            tag_q.push_back(tagfor(s, ins, extra));
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk_idle();
        @(negedge clk);
        checks++;
        if (act !== '0) begin
            errors++;
            $display("FAIL R1: strobes in reset actual %b expected %b", act, {VEC_W{1'b0}});
        end
    endtask

    // Monitor: compare scoreboard items and check that the bus has one driver.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            m_exp = exp_q.pop_front();
            m_tag = tag_q.pop_front();
            checks++;
            if (act !== m_exp) begin
                errors++;
                $display("FAIL %s: strobes actual %b expected %b", m_tag, act, m_exp);
            end
        end
        if (rst_n) begin
            checks++;
            if ($countones({pc_drive, alu_inc_drive, alu_add_drive, mdr_drive, gpr_drive}) > 1) begin
                errors++;
                $display("FAIL R11: bus drivers actual %0d expected at most 1",
                    $countones({pc_drive, alu_inc_drive, alu_add_drive, mdr_drive, gpr_drive}));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            errors++;
            $display("FAIL watchdog: cycles actual %0d expected below 5000", cyc);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) begin
            chk_idle();
            @(posedge clk);
            #1;
        end
        rst_n = 1'b1;
        run_steps(8'b00_010_101, 1'b0, 1'b0, 6, "R1");  // add r2 += r5
        run_steps(8'b00_111_001, 1'b0, 1'b0, 6, "");    // R12: add into program counter
        run_steps(8'b01_011_000, 1'b0, 1'b0, 6, "");    // R8: load r0 from [r3]
        run_steps(8'b01_111_100, 1'b0, 1'b0, 6, "");    // R12: address from program counter
        run_steps(8'b01_100_111, 1'b0, 1'b0, 6, "");    // R12: load into program counter
        run_steps(8'b10_001_010, 1'b0, 1'b0, 6, "");    // R9: jump
        run_steps(8'b11_011_100, 1'b1, 1'b0, 6, "");    // R10: negative taken
        run_steps(8'b11_011_100, 1'b0, 1'b1, 6, "");    // R10: zero taken
        run_steps(8'b11_011_100, 1'b0, 1'b0, 6, "");    // R10: suppressed
        run_steps(8'b11_101_110, 1'b1, 1'b1, 6, "");    // R10: both flags
        run_steps(8'b00_000_110, 1'b1, 1'b1, 6, "");    // R7: flags ignored by add
        // R1: reset in the middle of an instruction, then restart at fetch
        run_steps(8'b00_001_010, 1'b0, 1'b0, 4, "");
        rst_n = 1'b0;
        chk_idle();
        @(posedge clk);
        #1;
        chk_idle();
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        run_steps(8'b01_110_011, 1'b0, 1'b0, 6, "R1");
        run_steps(8'b10_111_111, 1'b0, 1'b0, 6, "");    // R12: both fields at index 7
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule